// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a one-shot countdown timer that counts whole seconds. Software computes how many seconds lie between now and the wanted alarm time, loads that interval into a 32-bit register, and sets the run bit. A single-cycle pulse on the once-per-second `tick` input lowers the count by one. When the count goes from one to zero, a sticky pending flag is set. The flag drives an interrupt line and a wakeup line, and each line has its own enable bit.

Access is through a simple 32-bit register port. A write takes effect at the clock edge where `bus_wr` is high. A read returns its data on `bus_rdata` one clock after the edge that samples `bus_rd`.

The safe way to reprogram the block is:
1. Clear the run bit.
2. Clear the pending flag.
3. Write zero to the interval.
4. Wait for one tick.
5. Write the new interval.
6. Set the run bit again.

A busy bit in the control word shows when a newly loaded interval is still waiting for its first tick. Two flag registers and a status word for a separate weekly alarm are kept as storage only.

Top module: `alarm_countdown`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` and `wake` are low.
- R2: A write to offset 0x20 stores the interval, which reads back at 0x20. The same write loads the live count, which reads at 0x24.
- R3: A tick lowers the count by one only when bit 0 of offset 0x28 (run) is 1 and the count is nonzero. A count of 0 stays 0.
- R4: The pending flag (bit 0 of offset 0x30) is set when a tick takes the count from 1 to 0. Further ticks while the count stays 0 do not set it again.
- R5: Writing 1 to bit 0 of offset 0x30 clears the pending flag. Writing 0 to that bit leaves the flag unchanged.
- R6: If a clear of the pending flag and an expiry fall in the same cycle, the flag ends up set.
- R7: `irq` is high one clock after the pending flag and bit 0 of offset 0x2C are both 1, and is low otherwise.
- R8: `wake` is high one clock after the pending flag and bit 0 of offset 0x50 are both 1, and is low otherwise.
- R9: Bit 9 of offset 0x00 (busy) goes to 1 on an interval write and goes back to 0 on the next tick. A tick in the same cycle as an interval write does not lower the freshly loaded count.
- R10: Bit 0 of offsets 0x44 and 0x48 can be read and written. Bit 0 of 0x4C is write-one-to-clear and reads 0. Writes to 0x24 are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid one clock after the read |
| irq | output | 1 | Registered interrupt line |
| wake | output | 1 | Registered wakeup line |

## Verification
The bound checker watches the counter's step rule on every cycle:
- the count changes only by a one-step decrement on an enabled tick, unless an interval write intervenes;
- a zero count stays zero;
- the pending flag rises only out of a 1-to-0 step;
- a clear always works unless an expiry falls in the same cycle;
- the outputs never rise without pending set in the previous cycle;
- an interval write always raises busy.

The scoreboard scenarios cover the behaviours that need a chosen sequence of events:
- the collision of a clear with an expiry;
- a tick landing on the same cycle as a load;
- the busy bit clearing on a tick;
- the weekly storage registers;
- writes to read-only or unmapped offsets having no effect.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  // register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_IVAL  = 'h20;
  localparam int OFS_CUR   = 'h24;
  localparam int OFS_RUN   = 'h28;
  localparam int OFS_IEN   = 'h2C;
  localparam int OFS_STAT  = 'h30;
  localparam int OFS_WK_EN = 'h44;
  localparam int OFS_WK_IE = 'h48;
  localparam int OFS_WK_ST = 'h4C;
  localparam int OFS_WAKE  = 'h50;
  localparam int BUSY_BIT  = 9;

  // index of each plain single-bit config register
  localparam int CFG_RUN   = 0;
  localparam int CFG_IEN   = 1;
  localparam int CFG_WKEN  = 2;
  localparam int CFG_WEN   = 3;
  localparam int CFG_WIE   = 4;
  localparam int CFG_COUNT = 5;

  typedef struct packed {
    logic load;   // interval write
    logic clr;    // pending clear (wdata bit 0 set)
    logic wk_clr; // weekly status clear
  } alarm_strb_t;
endpackage

// File: rtl/alarm_decode.sv
module alarm_decode
  import alarm_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic          wbit0,
  output alarm_strb_t   strb
);
  always_comb begin
    strb.load   = bus_wr && (bus_addr == AW'(OFS_IVAL));
    strb.clr    = bus_wr && (bus_addr == AW'(OFS_STAT)) && wbit0;
    strb.wk_clr = bus_wr && (bus_addr == AW'(OFS_WK_ST)) && wbit0;
  end
endmodule

// File: rtl/alarm_cfg.sv
module alarm_cfg
  import alarm_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 wbit0,
  input  logic                 wk_clr,
  output logic [CFG_COUNT-1:0] cfg,
  output logic                 wk_stat
);
  localparam int CFG_OFS [CFG_COUNT] = '{OFS_RUN, OFS_IEN, OFS_WAKE, OFS_WK_EN, OFS_WK_IE};

  for (genvar i = 0; i < CFG_COUNT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i] <= 1'b0;
      end else if (bus_wr && (bus_addr == AW'(CFG_OFS[i]))) begin
        cfg[i] <= wbit0;
      end
    end
  end

  // weekly status: kept as storage only, no set source inside this block
  always_ff @(posedge clk) begin
    if (rst || wk_clr) begin
      wk_stat <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          load,
  input  logic          clr,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] ival,
  output logic [CW-1:0] cnt,
  output logic          pend,
  output logic          busy
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic step;
  logic expire;

  always_comb begin
    step   = tick && run && (cnt != '0) && !load;
    expire = step && (cnt == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ival <= '0;
      cnt  <= '0;
    end else if (load) begin
      ival <= load_val;
      cnt  <= load_val;
    end else if (step) begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (expire) begin
      pend <= 1'b1;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
    end else if (tick) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
  import alarm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          wake
);
  alarm_strb_t          strb;
  logic [CFG_COUNT-1:0] cfg;
  logic                 wk_stat;
  logic [CW-1:0]        ival_q;
  logic [CW-1:0]        cnt_q;
  logic                 pend_q;
  logic                 busy_q;
  logic                 run_en;
  logic [DW-1:0]        rd_mux;

  alarm_decode #(.AW(AW)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbit0    (bus_wdata[0]),
    .strb     (strb)
  );

  alarm_cfg #(.AW(AW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbit0    (bus_wdata[0]),
    .wk_clr   (strb.wk_clr),
    .cfg      (cfg),
    .wk_stat  (wk_stat)
  );

  assign run_en = cfg[CFG_RUN];

  alarm_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (run_en),
    .load     (strb.load),
    .clr      (strb.clr),
    .load_val (bus_wdata[CW-1:0]),
    .ival     (ival_q),
    .cnt      (cnt_q),
    .pend     (pend_q),
    .busy     (busy_q)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFS_CTRL):  rd_mux[BUSY_BIT] = busy_q;
      AW'(OFS_IVAL):  rd_mux = DW'(ival_q);
      AW'(OFS_CUR):   rd_mux = DW'(cnt_q);
      AW'(OFS_RUN):   rd_mux[0] = cfg[CFG_RUN];
      AW'(OFS_IEN):   rd_mux[0] = cfg[CFG_IEN];
      AW'(OFS_STAT):  rd_mux[0] = pend_q;
      AW'(OFS_WK_EN): rd_mux[0] = cfg[CFG_WEN];
      AW'(OFS_WK_IE): rd_mux[0] = cfg[CFG_WIE];
      AW'(OFS_WK_ST): rd_mux[0] = wk_stat;
      AW'(OFS_WAKE):  rd_mux[0] = cfg[CFG_WKEN];
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
      wake      <= 1'b0;
    end else begin
      if (bus_rd) begin
        bus_rdata <= rd_mux;
      end
      irq  <= pend_q && cfg[CFG_IEN];
      wake <= pend_q && cfg[CFG_WKEN];
    end
  end
endmodule

// File: rtl/alarm_countdown_chk.sv
module alarm_countdown_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          irq,
  input logic          wake,
  input logic [CW-1:0] cnt,
  input logic          pend,
  input logic          busy,
  input logic          run
);
  logic ld;
  logic clr;
  assign ld  = bus_wr && (bus_addr == AW'('h20));
  assign clr = bus_wr && (bus_addr == AW'('h30)) && bus_wdata[0];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(ld) && (cnt != $past(cnt))) |-> ($past(tick) && $past(run) && (cnt == $past(cnt) - CW'(1)))); // R3
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(ld) && ($past(cnt) == '0)) |-> (cnt == '0)); // R3
  AST_PEND_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> ($past(tick) && ($past(cnt) == CW'(1)) && (cnt == '0))); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !($past(tick) && $past(run) && ($past(cnt) == CW'(1)) && !$past(ld))) |-> !pend); // R5
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pend)); // R7
  AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(pend)); // R8
  AST_BUSY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(ld) |-> busy); // R9
endmodule

bind alarm_countdown alarm_countdown_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .wake      (wake),
  .cnt       (cnt_q),
  .pend      (pend_q),
  .busy      (busy_q),
  .run       (run_en)
);

// File: tb/alarm_countdown_test.sv
`timescale 1ns/1ps
module alarm_countdown_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;
  logic          wake;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct { logic [DW-1:0] exp; string tag; } item_t;
  item_t sb[$];
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  alarm_countdown #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake)
  );

  // monitor: compare read results against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      it = sb.pop_front();
      applied++;
      if (bus_rdata !== it.exp) begin
        miscompares++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic cyc(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit tk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic pulse();
    cyc(1'b0, '0, '0, 1'b1);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    applied++;
    if (act !== e) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", tag, act, e);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd('h24, 0, "R1 count");
    rd('h30, 0, "R1 pending");
    rd('h00, 0, "R1 ctrl");
    rd('h20, 0, "R1 interval");
    chk(irq, 1'b0, "R1 irq");
    chk(wake, 1'b0, "R1 wake");

    // R2 load, R9 busy
    wr('h20, 5);
    idle(); idle();
    rd('h00, 32'h200, "R9 busy after load");
    rd('h20, 5, "R2 interval readback");
    rd('h24, 5, "R2 count loaded");

    // R3 no decrement while stopped; R9 tick clears busy
    pulse(); pulse();
    rd('h24, 5, "R3 hold while run=0");
    rd('h00, 0, "R9 busy cleared by tick");

    wr('h28, 1);
    wr('h2C, 1);
    pulse(); pulse(); pulse();
    rd('h24, 2, "R3 decrement");
    pulse();
    rd('h30, 0, "R4 not pending at 1");
    pulse();
    rd('h24, 0, "R3 reached zero");
    rd('h30, 1, "R4 pending on 1 to 0");
    chk(irq, 1'b1, "R7 irq with enable");
    chk(wake, 1'b0, "R8 wake disabled");
    wr('h50, 1);
    idle();
    chk(wake, 1'b1, "R8 wake enabled");

    // R5 clear semantics
    wr('h30, 0);
    rd('h30, 1, "R5 write 0 keeps pending");
    wr('h30, 1);
    idle();
    rd('h30, 0, "R5 write 1 clears");
    chk(irq, 1'b0, "R7 irq drops after clear");
    chk(wake, 1'b0, "R8 wake drops after clear");

    // R4/R3 ticks at zero do nothing
    pulse(); pulse();
    rd('h30, 0, "R4 no re-set at zero");
    rd('h24, 0, "R3 zero holds");

    // R9 tick coincident with load: load wins
    cyc(1'b1, 'h20, 3, 1'b1);
    rd('h24, 3, "R9 load beats tick");
    pulse(); pulse();
    rd('h24, 1, "R3 count at one");

    // R6 clear and expiry together
    cyc(1'b1, 'h30, 1, 1'b1);
    rd('h30, 1, "R6 expiry beats clear");
    wr('h2C, 0);
    idle();
    chk(irq, 1'b0, "R7 irq masked");
    chk(wake, 1'b1, "R8 wake still high");

    // R10 weekly storage and ignored accesses
    wr('h44, 1);
    wr('h48, 1);
    rd('h44, 1, "R10 weekly enable");
    rd('h48, 1, "R10 weekly irq enable");
    wr('h4C, 1);
    rd('h4C, 0, "R10 weekly status");
    wr('h24, 32'h77);
    rd('h24, 0, "R10 count write ignored");
    rd('h60, 0, "R10 unmapped read");
    wr('h44, 0);
    rd('h44, 0, "R10 weekly enable cleared");

    idle(); idle();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule